// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

This block drives a single fixed-frequency PWM pin whose average duty can be set more finely than one tick of its period counter. With the default parameters a 36 MHz clock counts 360 ticks per period, which gives a 100 kHz output. The duty command is given in units of 1/3600 of a period. That is ten times finer than the counter, and the extra precision is reached by dithering. Over a frame of ten consecutive periods, some periods use the coarse compare value and the others use the next value up. The mix is chosen so that the average over the frame equals the command.

The command is split into a coarse step (the command divided by the frame length) and a fraction (the remainder). A modulo accumulator is stepped once per period and spreads the higher periods evenly across the frame rather than grouping them together. A load strobe captures a new command at any time. The captured command only takes effect at the next frame boundary, so a frame never mixes two commands. A one-clock period-start pulse marks the first clock of every period, and it can be used to align sampling or a filter downstream.

The pin and the pulse can be taken straight from the counter compare or through an output register. The register is the default and delays both by one clock while keeping them aligned.

Top module: `pwm_dither_gen`

## Requirements
- R1: The period counter runs from 0 to PERIOD_CNT-1 (359) and wraps, so consecutive period-start pulses are exactly PERIOD_CNT (360) clocks apart.
- R2: `period_start_o` is high for exactly one clock at the first clock of every period. With the default registered output, the first pulse is seen after the first rising edge following reset release.
- R3: Within a period, `pwm_o` is high for the first cmp clocks, counted from the period-start clock, and low for the rest. The compare value cmp is fixed for the whole period.
- R4: A command c below 3600 is split into coarse = c/10 and f = c mod 10. In each frame of 10 periods, exactly f periods use cmp = coarse+1 and the rest use cmp = coarse, so the frame holds exactly c high clocks.
- R5: Periods are numbered k = 1..10 within a frame. Period k uses coarse+1 exactly when floor(k*f/10) > floor((k-1)*f/10), so the higher periods are spread evenly.
- R6: A command of 0 gives a constant low output. Any command of 3600 or more (up to 4095) gives a constant high output, with cmp = 360 in every period.
- R7: `load_i` high at a rising edge captures `cmd_i`. The captured command takes effect only from the first period of the next frame; a load in the very last clock of a frame applies to the frame that follows it. Without a new load, the last active command repeats frame after frame.
- R8: While reset is asserted, `pwm_o` and `period_start_o` are low. After reset, frames start at the first period and the active command is 0.
- R9: If several loads occur within one frame, only the last one before the boundary is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock (36 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | CMD_W (12) | Duty command in units of 1/(PERIOD_CNT*DITHER_N) of a period |
| load_i | input | 1 | Capture strobe for cmd_i |
| pwm_o | output | 1 | PWM output pin |
| period_start_o | output | 1 | One-clock pulse at the first clock of each period |

## Verification
The case hardest to reach from the ports is a load that lands in the final clock of a frame. That is the one edge where a new command is both captured and promoted to active, and a slip by one clock would make a frame mix two commands or apply a stale one. The stimulus waits until the bench's own period and tick counts show the last clock of a frame, then raises the strobe there. It also issues bursts of several loads inside one frame and drives commands at 0, 3599, 3600 and the largest code. A behavioural reference predicts the pin and the pulse on every clock, and an independent tally of high clocks per frame is compared with the command that frame should carry.

// File: rtl/pwm_dither_pkg.sv
`timescale 1ns/1ps
package pwm_dither_pkg;

   // Selects how the PWM pin and the period-start pulse leave the block
   typedef enum logic {
      OUT_COMB = 1'b0,   // straight from the compare logic
      OUT_REGD = 1'b1    // through one flop, one clock later
   } out_mode_e;

   // Width needed to hold values 0..v-1, never less than one bit
   function automatic int unsigned idx_width(input int unsigned v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

   // Width needed to hold values 0..v inclusive
   function automatic int unsigned val_width(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/pwm_period_timer.sv
`timescale 1ns/1ps
module pwm_period_timer #(
   parameter int unsigned PERIOD_CNT = 360,
   parameter int unsigned CNT_W      = 9
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [CNT_W-1:0] cnt_o,
   output logic             first_o,
   output logic             last_o
);

   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PERIOD_CNT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST_C) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o   = cnt_q;
   assign first_o = (cnt_q == '0);
   assign last_o  = (cnt_q == LAST_C);

   AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST_C);  // R1
   AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == LAST_C) |=> (cnt_q == '0));  // R1
   AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != LAST_C) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));  // R1

endmodule

// File: rtl/pwm_cmd_frame.sv
`timescale 1ns/1ps
module pwm_cmd_frame #(
   parameter int unsigned DITHER_N = 10,
   parameter int unsigned CMD_W    = 12,
   parameter int unsigned IDX_W    = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             period_end_i,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic             load_i,
   output logic [CMD_W-1:0] next_cmd_o,
   output logic             new_frame_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DITHER_N - 1);

   logic [CMD_W-1:0] pend_q, pend_d;
   logic [CMD_W-1:0] act_q;
   logic [IDX_W-1:0] idx_q;
   logic             frame_end;

   // A load in the same clock as the frame boundary is already visible here
   assign pend_d    = load_i ? cmd_i : pend_q;
   assign frame_end = period_end_i && (idx_q == LAST_IDX);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
         act_q  <= '0;
         idx_q  <= '0;
      end else begin
         pend_q <= pend_d;
         if (period_end_i) begin
            idx_q <= frame_end ? '0 : idx_q + IDX_W'(1);
         end
         if (frame_end) begin
            act_q <= pend_d;
         end
      end
   end

   assign next_cmd_o  = frame_end ? pend_d : act_q;
   assign new_frame_o = frame_end;

   AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_end |=> $stable(act_q));  // R7
   AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_q <= LAST_IDX);  // R4
   AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !period_end_i |=> $stable(idx_q));  // R4
   AST_LAST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (pend_q == $past(cmd_i)));  // R9

endmodule

// File: rtl/pwm_dither_accum.sv
`timescale 1ns/1ps
module pwm_dither_accum #(
   parameter int unsigned PERIOD_CNT = 360,
   parameter int unsigned DITHER_N   = 10,
   parameter int unsigned CMD_W      = 12,
   parameter int unsigned CNT_W      = 9,
   parameter int unsigned FR_W       = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             period_end_i,
   input  logic             new_frame_i,
   input  logic [CMD_W-1:0] cmd_i,
   output logic [CNT_W-1:0] cmp_o
);

   localparam int unsigned SUM_W = FR_W + 1;
   localparam int unsigned FULL  = PERIOD_CNT * DITHER_N;
   localparam logic [CMD_W-1:0] FULL_C = CMD_W'(FULL);
   localparam logic [CMD_W-1:0] DIV_C  = CMD_W'(DITHER_N);
   localparam logic [SUM_W-1:0] MOD_C  = SUM_W'(DITHER_N);
   localparam logic [CNT_W-1:0] TOP_C  = CNT_W'(PERIOD_CNT);
   localparam bit   POW2_N = ((DITHER_N & (DITHER_N - 1)) == 0);

   logic [CNT_W-1:0] coarse_raw, coarse;
   logic [FR_W-1:0]  frac_raw, frac;
   logic             sat;
   logic [FR_W-1:0]  acc_q, acc_d, base;
   logic [SUM_W-1:0] sum;
   logic             carry;
   logic [CNT_W-1:0] cmp_q, cmp_d;

   // Coarse / fraction split: bit slicing for a power-of-two frame, divider otherwise
   generate
      if (POW2_N) begin : g_split_shift
         assign coarse_raw = CNT_W'(cmd_i >> FR_W);
         assign frac_raw   = cmd_i[FR_W-1:0];
      end else begin : g_split_div
         logic [CMD_W-1:0] quo, rem;
         assign quo        = cmd_i / DIV_C;
         assign rem        = cmd_i % DIV_C;
         assign coarse_raw = quo[CNT_W-1:0];
         assign frac_raw   = rem[FR_W-1:0];
      end
   endgenerate

   // Commands at or beyond full scale saturate to a full-high period
   assign sat    = (cmd_i >= FULL_C);
   assign coarse = sat ? TOP_C : coarse_raw;
   assign frac   = sat ? '0 : frac_raw;

   // Accumulator restarts at zero on every frame so each frame holds exactly f carries
   assign base  = new_frame_i ? '0 : acc_q;
   assign sum   = {1'b0, base} + {1'b0, frac};
   assign carry = (sum >= MOD_C);
   assign acc_d = carry ? FR_W'(sum - MOD_C) : sum[FR_W-1:0];
   assign cmp_d = coarse + CNT_W'(carry);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
         cmp_q <= '0;
      end else if (period_end_i) begin
         acc_q <= acc_d;
         cmp_q <= cmp_d;
      end
   end

   assign cmp_o = cmp_q;

   AST_ACC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_q < FR_W'(DITHER_N));  // R5
   AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !period_end_i |=> $stable(cmp_q));  // R3
   AST_CMP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_q <= TOP_C);  // R6
   AST_SAT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_end_i && sat) |=> (cmp_q == TOP_C));  // R6
   AST_ZERO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_end_i && (cmd_i == '0)) |=> (cmp_q == '0));  // R6

endmodule

// File: rtl/pwm_out_stage.sv
`timescale 1ns/1ps
module pwm_out_stage #(
   parameter int unsigned               PERIOD_CNT = 360,
   parameter int unsigned               CNT_W      = 9,
   parameter pwm_dither_pkg::out_mode_e OUT_MODE   = pwm_dither_pkg::OUT_REGD
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             first_i,
   output logic             pwm_o,
   output logic             start_o
);

   localparam logic [CNT_W-1:0] TOP_C = CNT_W'(PERIOD_CNT);

   logic pwm_raw;
   assign pwm_raw = (cnt_i < cmp_i);

   generate
      if (OUT_MODE == pwm_dither_pkg::OUT_REGD) begin : g_out_reg
         logic pwm_q, start_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pwm_q   <= 1'b0;
               start_q <= 1'b0;
            end else begin
               pwm_q   <= pwm_raw;
               start_q <= first_i;
            end
         end
         assign pwm_o   = pwm_q;
         assign start_o = start_q;

         AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cmp_i == TOP_C) |=> pwm_o);  // R6
         AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cmp_i == '0) |=> !pwm_o);  // R6
      end else begin : g_out_comb
         assign pwm_o   = pwm_raw;
         assign start_o = first_i;

         AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cmp_i == TOP_C) |-> pwm_o);  // R6
         AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cmp_i == '0) |-> !pwm_o);  // R6
      end
   endgenerate

endmodule

// File: rtl/pwm_dither_gen.sv
`timescale 1ns/1ps
module pwm_dither_gen #(
   parameter int unsigned               PERIOD_CNT = 360,
   parameter int unsigned               DITHER_N   = 10,
   parameter int unsigned               CMD_W      = 12,
   parameter pwm_dither_pkg::out_mode_e OUT_MODE   = pwm_dither_pkg::OUT_REGD
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic             load_i,
   output logic             pwm_o,
   output logic             period_start_o
);

   localparam int unsigned CNT_W = pwm_dither_pkg::val_width(PERIOD_CNT);
   localparam int unsigned FR_W  = pwm_dither_pkg::idx_width(DITHER_N);
   localparam int unsigned IDX_W = pwm_dither_pkg::idx_width(DITHER_N);
   localparam int unsigned FULL  = PERIOD_CNT * DITHER_N;

   // Elaboration-time parameter checks
   initial begin : p_param_chk
      assert (PERIOD_CNT >= 2)
         else $fatal(1, "PERIOD_CNT must be at least 2");
      assert (DITHER_N >= 2)
         else $fatal(1, "DITHER_N must be at least 2");
      assert (CMD_W <= 31 && (64'(1) << CMD_W) > 64'(FULL))
         else $fatal(1, "CMD_W too narrow for full-scale command");
      assert (CNT_W <= CMD_W)
         else $fatal(1, "CMD_W narrower than counter width");
   end

   logic [CNT_W-1:0] cnt;
   logic             first, last;
   logic [CMD_W-1:0] next_cmd;
   logic             new_frame;
   logic [CNT_W-1:0] cmp;

   pwm_period_timer #(
      .PERIOD_CNT (PERIOD_CNT),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_o   (cnt),
      .first_o (first),
      .last_o  (last)
   );

   pwm_cmd_frame #(
      .DITHER_N (DITHER_N),
      .CMD_W    (CMD_W),
      .IDX_W    (IDX_W)
   ) u_frame (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .period_end_i (last),
      .cmd_i        (cmd_i),
      .load_i       (load_i),
      .next_cmd_o   (next_cmd),
      .new_frame_o  (new_frame)
   );

   pwm_dither_accum #(
      .PERIOD_CNT (PERIOD_CNT),
      .DITHER_N   (DITHER_N),
      .CMD_W      (CMD_W),
      .CNT_W      (CNT_W),
      .FR_W       (FR_W)
   ) u_accum (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .period_end_i (last),
      .new_frame_i  (new_frame),
      .cmd_i        (next_cmd),
      .cmp_o        (cmp)
   );

   pwm_out_stage #(
      .PERIOD_CNT (PERIOD_CNT),
      .CNT_W      (CNT_W),
      .OUT_MODE   (OUT_MODE)
   ) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_i   (cnt),
      .cmp_i   (cmp),
      .first_i (first),
      .pwm_o   (pwm_o),
      .start_o (period_start_o)
   );

   AST_START_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      period_start_o |=> !period_start_o);  // R2

endmodule

// File: tb/tb_pwm_dither_gen.sv
`timescale 1ns/1ps
module tb_pwm_dither_gen;

   localparam int P = 360;
   localparam int N = 10;
   localparam int W = 12;
   localparam int FULL = P * N;

   logic         clk   = 1'b0;
   logic         rst_n = 1'b0;
   logic         load  = 1'b0;
   logic [W-1:0] cmd   = '0;
   logic         pwm, ps;

   always #2 clk = ~clk;   // 250 MHz

   pwm_dither_gen dut (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .cmd_i          (cmd),
      .load_i         (load),
      .pwm_o          (pwm),
      .period_start_o (ps)
   );

   int    vectors = 0;
   int    fails   = 0;
   string phase   = "R8";
   bit    done    = 1'b0;

   // ---------------- behavioural reference ----------------
   int m_cnt = 0, m_per = 0, m_pend = 0, m_act = 0, m_cmp = 0;
   bit e_pwm = 1'b0, e_ps = 1'b0;
   int frame_q[$];

   // Compare value of period k (1..N) of a frame carrying command c (R4, R5, R6)
   function automatic int cmp_for(input int c, input int k);
      int crs, f;
      if (c >= FULL) return P;
      crs = c / N;
      f   = c % N;
      return crs + (((k * f) / N > ((k - 1) * f) / N) ? 1 : 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin : mdl
      int nc, np;
      if (!rst_n) begin
         m_cnt <= 0; m_per <= 0; m_pend <= 0; m_act <= 0; m_cmp <= 0;
         e_pwm <= 1'b0; e_ps <= 1'b0;
      end else begin
         e_pwm <= (m_cnt < m_cmp);
         e_ps  <= (m_cnt == 0);
         nc = load ? int'(cmd) : m_pend;
         m_pend <= nc;
         if (m_cnt == P - 1) begin
            m_cnt <= 0;
            np = (m_per + 1) % N;
            m_per <= np;
            if (np == 0) begin
               m_act <= nc;
               m_cmp <= cmp_for(nc, 1);
               frame_q.push_back(nc);
            end else begin
               m_cmp <= cmp_for(m_act, np + 1);
            end
         end else begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   // ---------------- checker ----------------
   int gap = 0, per_seen = 0, hi_sum = 0;

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            vectors++;
            if (pwm !== 1'b0 || ps !== 1'b0) begin
               fails++;
               $display("FAIL R8 outputs in reset: pwm=%b ps=%b expected 0 0", pwm, ps);
            end
         end else begin
            vectors++;
            if (pwm !== e_pwm) begin
               fails++;
               $display("FAIL R3 (%s) pwm_o at %0t: got %b expected %b", phase, $time, pwm, e_pwm);
            end
            if (ps !== e_ps) begin
               fails++;
               $display("FAIL R2 period_start_o at %0t: got %b expected %b", $time, ps, e_ps);
            end
            gap++;
            if (ps === 1'b1) begin
               if (per_seen > 0 && gap != P) begin   // R1 period length
                  fails++;
                  $display("FAIL R1 period length: got %0d expected %0d", gap, P);
               end
               if (per_seen > 0 && per_seen % N == 0) begin   // R4 high clocks per frame
                  int exp_c;
                  exp_c = (frame_q.size() > 0) ? frame_q.pop_front() : -1;
                  if (exp_c > FULL) exp_c = FULL;
                  vectors++;
                  if (hi_sum != exp_c) begin
                     fails++;
                     $display("FAIL R4 (%s) frame high clocks: got %0d expected %0d", phase, hi_sum, exp_c);
                  end
                  hi_sum = 0;
               end
               gap = 0;
               per_seen++;
            end
            if (pwm === 1'b1) hi_sum++;
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic run_frames(input int n);
      repeat (n * P * N) @(negedge clk);
   endtask

   task automatic load_now(input int v);
      @(negedge clk);
      cmd  = W'(v);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   // Raise load in the last clock of a frame (R7 boundary case)
   task automatic load_at_frame_end(input int v);
      @(negedge clk);
      while (!(m_cnt == P - 1 && m_per == N - 1)) @(negedge clk);
      cmd  = W'(v);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      frame_q.push_back(0);           // first frame after reset carries command 0 (R8)
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      phase = "R8";
      run_frames(1);

      phase = "R4";                   // mixed coarse and fraction
      load_now(1234);
      run_frames(3);

      phase = "R5";                   // pure fraction, spread pattern visible
      load_now(7);
      run_frames(2);
      load_now(3);
      run_frames(2);

      phase = "R6";                   // clamp ends
      load_now(0);
      run_frames(2);
      load_now(3600);
      run_frames(2);
      load_now(4095);
      run_frames(1);
      load_now(3599);
      run_frames(2);

      phase = "R7";                   // load on the very last clock of a frame
      load_at_frame_end(1805);
      run_frames(2);
      load_now(500);
      run_frames(2);

      phase = "R9";                   // several loads in one frame, last wins
      load_now(100);
      repeat (700) @(negedge clk);
      load_now(2);
      repeat (900) @(negedge clk);
      load_now(2999);
      run_frames(2);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired: got hung run expected completion");
         summary();
         $finish;
      end
   end

endmodule